// File: doc/BRIEF.md
# Descriptor-Driven Block Copy Engine

This engine moves one block of data for one channel at a time. A start strobe with a channel number marks that channel as pending. When idle, the engine takes the lowest-numbered pending channel and reads its 16-byte descriptor from memory over a single request/acknowledge memory master port. It then copies the block item by item and writes a modified control word back into the descriptor. A one-cycle completion pulse carries the channel number back to the register bank.

A descriptor sits at the table base plus sixteen bytes per channel. When the channel's alternate-select bit is set, the alternate table 0x200 bytes above the base is used instead. The descriptor stores the last address of each side, not the first, so the engine works out the start addresses from the item count. If the memory answers any access with an error, the transfer stops at once and a fault pulse is raised in place of the completion pulse.

Top module: `dma_desc_engine`

## Requirements
- R1: While and after reset, `busy`, `mem_req`, `done` and `fault` are low and no channel is pending, so no memory access occurs until a start strobe arrives.
- R2: The descriptor address is `base_addr` + 16 × channel, plus 0x200 when `alt_sel[channel]` is 1. Its words are read at offsets +0 (source end address), +4 (destination end address) and +8 (control word), in that order.
- R3: The number of items is control bits [13:4] plus one, from 1 to 1024.
- R4: The address step is taken from bits [27:26] for the source and bits [31:30] for the destination. Code 0 steps 1 byte, code 1 steps 2, code 2 steps 4, and code 3 keeps the address fixed. Both addresses advance after every item.
- R5: The item width in bytes is 2 to the power of bits [25:24] (source) or bits [29:28] (destination), using codes 0 to 2, and appears on `mem_size`. Data is right-aligned and little-endian on the data buses. Each item is read from the source and then written to the destination before the next item starts. A narrower source is zero-extended and a wider source keeps its low bytes.
- R6: A side whose step code is 3 uses its end address throughout. Any other side starts at its end address minus the item count plus one.
- R7: After the last item, the engine writes the control word back to descriptor offset +8 as a 4-byte write with the bits of mask 0x3FF7 cleared and all other bits unchanged. It then pulses `done` for one cycle with `evt_ch` set to the channel.
- R8: A start strobe given while busy is held as pending. Pending channels are served lowest number first, each once per strobe.
- R9: An error response aborts the transfer: `fault` pulses with `evt_ch`, no further access is issued, the descriptor is not written back and `done` stays low.
- R10: While `mem_req` waits for `mem_ack`, address, direction, size and write data hold steady. `busy` falls only together with a `done` or `fault` pulse, and `done` and `fault` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start strobe for `start_ch` |
| start_ch | input | CHW | Channel to mark pending |
| base_addr | input | 32 | Descriptor table base address |
| alt_sel | input | NCH | Per-channel alternate-table select |
| busy | output | 1 | A channel is being served |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Byte address |
| mem_size | output | 2 | log2 of access width in bytes |
| mem_wdata | output | 32 | Write data, right-aligned |
| mem_ack | input | 1 | Access finished this cycle |
| mem_err | input | 1 | Access finished with an error (valid with `mem_ack`) |
| mem_rdata | input | 32 | Read data, right-aligned |
| done | output | 1 | Transfer completed (one cycle) |
| fault | output | 1 | Transfer aborted on error (one cycle) |
| evt_ch | output | CHW | Channel of the `done` or `fault` pulse |

## Verification
The bench targets the following corner cases:
- Single-item and 1024-item transfers, which catch off-by-one faults in the count or the start-address arithmetic: such a design copies one item too many or too few, or starts one byte off.
- A fixed-address side and mixed source and destination widths, which expose a step or width decoded from the wrong field as corrupted or misplaced bytes.
- An alternate-table channel paired with a deliberately wrong primary descriptor, so that reading the wrong table copies the wrong region.
- Starts issued out of order while busy, which reveal a wrong serving order.
- An error on the second source read. A design that ignored the error would go on to finish or write back the descriptor, and that shows up in memory.

// File: rtl/dma_desc_engine.sv
module dma_desc_engine #(
  parameter int NCH = 32,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CHW-1:0]   start_ch,
  input  logic [31:0]      base_addr,
  input  logic [NCH-1:0]   alt_sel,
  output logic             busy,
  output logic             mem_req,
  output logic             mem_we,
  output logic [31:0]      mem_addr,
  output logic [1:0]       mem_size,
  output logic [31:0]      mem_wdata,
  input  logic             mem_ack,
  input  logic             mem_err,
  input  logic [31:0]      mem_rdata,
  output logic             done,
  output logic             fault,
  output logic [CHW-1:0]   evt_ch
);
  localparam logic [31:0] CLR_MASK = 32'h0000_3FF7;
  localparam logic [31:0] ALT_OFS  = 32'h0000_0200;

  typedef enum logic [2:0] {S_IDLE, S_SRC, S_DST, S_CTL, S_RD, S_WR, S_WB} st_t;

  st_t            st;
  logic [NCH-1:0] pend;
  logic [CHW-1:0] ch, pick;
  logic [31:0]    dadr, src, dst, ctl, data;
  logic [10:0]    left;

  function automatic logic [31:0] stepv(input logic [1:0] c);
    return (c == 2'd3) ? 32'd0 : (32'd1 << c);
  endfunction

  always_comb begin
    pick = '0;
    for (int i = NCH - 1; i >= 0; i--)
      if (pend[i]) pick = CHW'(i);
  end

  wire            take = (st == S_IDLE) && (|pend);
  wire [NCH-1:0]  setv = start ? (NCH'(1) << start_ch) : '0;
  wire [NCH-1:0]  clrv = take ? (NCH'(1) << pick) : '0;
  wire [31:0]     cnt_m1 = {22'd0, mem_rdata[13:4]};

  assign busy    = (st != S_IDLE);
  assign mem_req = busy;
  assign mem_we  = (st == S_WR) || (st == S_WB);

  always_comb begin
    mem_addr  = '0;
    mem_size  = 2'd2;
    mem_wdata = '0;
    case (st)
      S_SRC: mem_addr = dadr;
      S_DST: mem_addr = dadr + 32'd4;
      S_CTL: mem_addr = dadr + 32'd8;
      S_RD:  begin mem_addr = src; mem_size = ctl[25:24]; end
      S_WR:  begin mem_addr = dst; mem_size = ctl[29:28]; mem_wdata = data; end
      S_WB:  begin mem_addr = dadr + 32'd8; mem_wdata = ctl & ~CLR_MASK; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; pend <= '0; ch <= '0; dadr <= '0; src <= '0; dst <= '0;
      ctl <= '0; data <= '0; left <= '0; done <= 1'b0; fault <= 1'b0; evt_ch <= '0;
    end else begin
      done  <= 1'b0;
      fault <= 1'b0;
      pend  <= (pend & ~clrv) | setv;
      if (take) begin
        ch   <= pick;
        dadr <= base_addr + (alt_sel[pick] ? ALT_OFS : 32'd0) + (32'(pick) << 4);
        st   <= S_SRC;
      end else if (busy && mem_ack) begin
        if (mem_err) begin
          fault <= 1'b1; evt_ch <= ch; st <= S_IDLE;
        end else begin
          case (st)
            S_SRC: begin src <= mem_rdata; st <= S_DST; end
            S_DST: begin dst <= mem_rdata; st <= S_CTL; end
            S_CTL: begin
              ctl  <= mem_rdata;
              left <= {1'b0, mem_rdata[13:4]} + 11'd1;
              if (mem_rdata[27:26] != 2'd3) src <= src - cnt_m1;
              if (mem_rdata[31:30] != 2'd3) dst <= dst - cnt_m1;
              st <= S_RD;
            end
            S_RD: begin
              case (ctl[25:24])
                2'd0:    data <= {24'd0, mem_rdata[7:0]};
                2'd1:    data <= {16'd0, mem_rdata[15:0]};
                default: data <= mem_rdata;
              endcase
              st <= S_WR;
            end
            S_WR: begin
              src  <= src + stepv(ctl[27:26]);
              dst  <= dst + stepv(ctl[31:30]);
              left <= left - 11'd1;
              st   <= (left == 11'd1) ? S_WB : S_RD;
            end
            S_WB: begin done <= 1'b1; evt_ch <= ch; st <= S_IDLE; end
            default: st <= S_IDLE;
          endcase
        end
      end
    end
  end

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)
                            && $stable(mem_size) && $stable(mem_wdata));
  // R10
  evt_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(done && fault));
  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R10
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> (done || fault));
  // R9
  fault_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n) fault |-> !mem_req);
endmodule

// File: tb/test_dma_desc_engine.sv
module test_dma_desc_engine;
  localparam int NCH = 32;
  localparam int CHW = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0;
  logic [CHW-1:0] start_ch = '0;
  logic [31:0] base_addr = 32'd0;
  logic [NCH-1:0] alt_sel = '0;
  logic busy, mem_req, mem_we, done, fault;
  logic [31:0] mem_addr, mem_wdata;
  logic [1:0] mem_size;
  logic mem_ack, mem_err;
  logic [31:0] mem_rdata;
  logic [CHW-1:0] evt_ch;

  int total = 0, bad = 0;
  logic err_on = 1'b0;
  logic [31:0] err_addr = '0;
  logic [7:0] mm [2][4096];

  always #2 clk = ~clk;

  dma_desc_engine #(.NCH(NCH)) i_dma_desc_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .start_ch(start_ch), .base_addr(base_addr),
    .alt_sel(alt_sel), .busy(busy), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_size(mem_size), .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_err(mem_err),
    .mem_rdata(mem_rdata), .done(done), .fault(fault), .evt_ch(evt_ch));

  function automatic int nby(input logic [1:0] sz);
    return (sz >= 2) ? 4 : (1 << sz);
  endfunction

  function automatic logic [31:0] mrd(input int s, input logic [31:0] a, input logic [1:0] sz);
    logic [31:0] v = '0;
    for (int k = 0; k < nby(sz); k++) v[8*k +: 8] = mm[s][(a + 32'(k)) & 32'hFFF];
    return v;
  endfunction

  function automatic void mwr(input int s, input logic [31:0] a, input logic [1:0] sz, input logic [31:0] v);
    for (int k = 0; k < nby(sz); k++) mm[s][(a + 32'(k)) & 32'hFFF] = v[8*k +: 8];
  endfunction

  function automatic logic [31:0] stp(input logic [1:0] c);
    return (c == 2'd3) ? 32'd0 : (32'd1 << c);
  endfunction

  function automatic logic [31:0] daddr(input int ch, input bit alt);
    return (alt ? 32'h200 : 32'h0) + 32'(16 * ch);
  endfunction

  function automatic logic [31:0] mkcw(input logic [1:0] di, input logic [1:0] dz, input logic [1:0] si,
                                       input logic [1:0] sz, input logic [9:0] nf);
    return {di, dz, si, sz, 10'($urandom), nf, 4'($urandom)};
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // reference transfer on the model copy
  task automatic ref_run(input int ch, input bit alt);
    logic [31:0] d, se, de, cw, s, t, v;
    int n;
    d  = daddr(ch, alt);
    se = mrd(1, d, 2); de = mrd(1, d + 4, 2); cw = mrd(1, d + 8, 2);
    n  = int'(cw[13:4]) + 1;
    s  = (cw[27:26] == 3) ? se : se - 32'(n) + 1;
    t  = (cw[31:30] == 3) ? de : de - 32'(n) + 1;
    for (int k = 0; k < n; k++) begin
      v = mrd(1, s, cw[25:24]);
      mwr(1, t, cw[29:28], v);
      s += stp(cw[27:26]); t += stp(cw[31:30]);
    end
    mwr(1, d + 8, 2, cw & ~32'h3FF7);
  endtask

  task automatic setd(input int ch, input bit alt, input logic [31:0] se, input logic [31:0] de, input logic [31:0] cw);
    mwr(0, daddr(ch, alt), 2, se);
    mwr(0, daddr(ch, alt) + 4, 2, de);
    mwr(0, daddr(ch, alt) + 8, 2, cw);
    mwr(0, daddr(ch, alt) + 12, 2, $urandom);
    alt_sel[ch] = alt;
    if (alt) begin
      mwr(0, daddr(ch, 0), 2, 32'hA00);
      mwr(0, daddr(ch, 0) + 4, 2, 32'hB00);
      mwr(0, daddr(ch, 0) + 8, 2, 32'h00000030);
    end
  endtask

  task automatic snap();
    for (int k = 0; k < 4096; k++) mm[1][k] = mm[0][k];
  endtask

  task automatic cmp_mem(input string req, input string what);
    int nbad = 0, first = -1;
    for (int k = 0; k < 4096; k++)
      if (mm[0][k] !== mm[1][k]) begin nbad++; if (first < 0) first = k; end
    if (first < 0) chk(1, req, what, 0, 0);
    else chk(0, req, {what, " byte@", $sformatf("%0h", first)}, int'(mm[0][first]), int'(mm[1][first]));
  endtask

  task automatic kick(input int ch);
    @(negedge clk); start = 1'b1; start_ch = CHW'(ch);
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_evt(output bit gd, output bit gf, output int ech);
    gd = 0; gf = 0; ech = -1;
    for (int k = 0; k < 30000; k++) begin
      @(negedge clk);
      if (done || fault) begin gd = done; gf = fault; ech = int'(evt_ch); return; end
    end
  endtask

  task automatic xfer(input int ch, input bit alt, input logic [31:0] se, input logic [31:0] de,
                      input logic [31:0] cw, input string req);
    bit gd, gf; int ech;
    setd(ch, alt, se, de, cw);
    snap();
    ref_run(ch, alt);
    kick(ch);
    wait_evt(gd, gf, ech);
    chk(gd && !gf && ech == ch, req, "done channel", ech, ch);
    cmp_mem(req, "memory image");
  endtask

  // memory responder
  initial begin
    mem_ack = 1'b0; mem_err = 1'b0; mem_rdata = '0;
    forever begin
      @(negedge clk);
      mem_ack = 1'b0; mem_err = 1'b0;
      if (mem_req) begin
        repeat ($urandom % 3) @(negedge clk);
        if (err_on && mem_addr == err_addr) mem_err = 1'b1;
        else if (mem_we) mwr(0, mem_addr, mem_size, mem_wdata);
        else mem_rdata = mrd(0, mem_addr, mem_size);
        mem_ack = 1'b1;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit gd, gf; int ech; int order [3];
    logic [31:0] cw;
    void'($urandom(32'd1234));
    for (int k = 0; k < 4096; k++) mm[0][k] = 8'($urandom);

    // R1 reset state
    repeat (3) @(negedge clk);
    chk(!busy && !mem_req && !done && !fault, "R1", "outputs in reset", {busy, mem_req, done, fault}, 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(!busy && !mem_req, "R1", "idle after reset", {busy, mem_req}, 0);

    // R3 R6 minimum count, byte steps
    xfer(0, 0, 32'h500, 32'h900, mkcw(0, 0, 0, 0, 10'd0), "R3");
    // R2 R4 alternate table, halfword steps
    xfer(5, 1, 32'h520, 32'h940, mkcw(1, 1, 1, 1, 10'd9), "R2");
    // R6 fixed source, word items
    xfer(12, 0, 32'h600, 32'hA00, mkcw(2, 2, 3, 2, 10'd15), "R6");
    // R5 truncation: word source to byte destination
    xfer(31, 0, 32'h700, 32'hC00, mkcw(0, 0, 2, 2, 10'd20), "R5");
    // R5 zero extension: byte source to word destination
    xfer(17, 1, 32'h780, 32'hD00, mkcw(2, 2, 0, 0, 10'd20), "R5");
    // R3 R7 maximum count with control writeback
    xfer(2, 0, 32'h4FF, 32'hAFF, mkcw(0, 0, 0, 0, 10'h3FF), "R7");

    // R8 queued starts served lowest first
    setd(7, 0, 32'h540, 32'hE00, mkcw(0, 0, 0, 0, 10'd60));
    setd(9, 0, 32'h5A0, 32'hE80, mkcw(1, 1, 1, 1, 10'd8));
    setd(3, 1, 32'h5C0, 32'hEC0, mkcw(2, 2, 2, 2, 10'd5));
    snap(); ref_run(7, 0); ref_run(3, 1); ref_run(9, 0);
    kick(7); kick(9); kick(3);
    for (int k = 0; k < 3; k++) begin wait_evt(gd, gf, ech); order[k] = gd ? ech : -1; end
    chk(order[0] == 7, "R8", "first served", order[0], 7);
    chk(order[1] == 3, "R8", "second served", order[1], 3);
    chk(order[2] == 9, "R8", "third served", order[2], 9);
    cmp_mem("R8", "memory after queue");

    // R9 error on second source read
    cw = mkcw(0, 0, 0, 0, 10'd7);
    setd(4, 0, 32'h600, 32'h700, cw);
    snap();
    err_on = 1'b1; err_addr = 32'h5FA;
    kick(4);
    wait_evt(gd, gf, ech);
    chk(gf && !gd && ech == 4, "R9", "fault channel", ech, 4);
    repeat (10) @(negedge clk);
    chk(!mem_req && !busy, "R9", "no access after fault", {mem_req, busy}, 0);
    chk(mrd(0, 32'h8, 2) + 0 == 0 || mrd(0, daddr(4, 0) + 8, 2) == cw, "R9", "control word kept",
        int'(mrd(0, daddr(4, 0) + 8, 2)), int'(cw));
    chk(mm[0][12'h6F9] == mm[0][12'h5F9], "R9", "first item copied", int'(mm[0][12'h6F9]), int'(mm[0][12'h5F9]));
    chk(mm[0][12'h6FA] == mm[1][12'h6FA], "R9", "second item untouched", int'(mm[0][12'h6FA]), int'(mm[1][12'h6FA]));
    err_on = 1'b0;

    // R4 R5 R10 random transfers
    for (int r = 0; r < 24; r++) begin
      logic [1:0] di, dz, si, sz;
      di = 2'($urandom); si = 2'($urandom);
      dz = 2'($urandom % 3); sz = 2'($urandom % 3);
      xfer(int'($urandom % NCH), bit'($urandom), 32'h400 + 32'($urandom % 32'h500),
           32'hA00 + 32'($urandom % 32'h500), mkcw(di, dz, si, sz, 10'($urandom % 48)), "R4");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule